// File: doc/BRIEF.md
# Dual-Lane Word Serializer

This block takes 20-bit words from an upstream word queue and sends them out as serial bit streams. It runs in the serial bit clock domain, where one BCO period lasts exactly twenty serial clocks. Each serial lane therefore carries exactly one whole word per BCO period. A configuration bit selects the lane mode. In two-lane mode up to two words leave per BCO period, one on each lane. In one-lane mode the words leave one after another on lane 0.

A small staging buffer collects words through a valid/ready handshake. At every word boundary, the buffer hands its oldest entries to the lane shifters. The first BCO-aligned start pulse fixes where the boundaries fall. After that pulse, a boundary comes every twenty clocks. A later pulse re-aligns the boundaries. If a lane has no word to send at a boundary, it sends a reserved idle code for the whole period. Producers must never enqueue that code as data.

Top module: `dual_lane_serializer`

## Requirements
- R1: After reset both serial outputs are high and `word_ready_o` is high. Until the first `bco_sync_i` pulse, the outputs hold still even if words are accepted.
- R2: A clock with `bco_sync_i` high is a word boundary, and so is every twentieth clock after it. From the clock that follows a boundary, each lane shifts its 20-bit word out most-significant bit first, one bit per clock. Lane 0 and lane 1 are `ser_o[0]` and `ser_o[1]`.
- R3: In two-lane mode (`two_lane_i` = 1) a boundary can take two words. Lane 0 gets the older one and lane 1 the next one, so two words leave in twenty clocks.
- R4: In one-lane mode (`two_lane_i` = 0) a boundary takes at most one word, which goes to lane 0. Lane 1 sends idle, so two words need forty clocks.
- R5: When a lane has no word at a boundary, it sends the idle code 20'hFFFFF (all ones) for that whole period.
- R6: In two-lane mode, if only one word is staged at a boundary, that word goes on lane 0 and lane 1 sends idle.
- R7: The mode is sampled only on boundary clocks. A mode change between boundaries takes effect at the next boundary.
- R8: `word_ready_o` is high exactly when fewer than two words are staged. Accepted words leave in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock, twenty per BCO period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 20 | Word offered by the upstream queue |
| word_valid_i | input | 1 | `word_i` holds a word |
| word_ready_o | output | 1 | Staging buffer can accept a word |
| two_lane_i | input | 1 | 1 = two-lane mode, 0 = one-lane mode |
| bco_sync_i | input | 1 | BCO-aligned start pulse; marks a word boundary |
| ser_o | output | 2 | Serial data, bit 0 = lane 0, bit 1 = lane 1 |

## Verification
A wrong bit counter shifts every later word by one or more bit positions, so the error shows at the next word boundary and stays. A wrong staging level or pop count shows as a dropped, repeated or reordered word on a lane within one BCO period, and also as a `word_ready_o` value that disagrees with the number of words accepted. A wrong mode sample puts data on lane 1 in one-lane mode, or idle where a word was due, within the first bit of the affected period.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int WORD_W  = 20;
  localparam int LANES   = 2;
  localparam logic [WORD_W-1:0] IDLE_WORD = '1;
endpackage

// File: rtl/dls_word_stage.sv
module dls_word_stage #(
  parameter int W     = 20,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic [W-1:0]              push_word_i,
  output logic                      ready_o,
  input  logic [CW-1:0]             pop_n_i,
  output logic [DEPTH-1:0][W-1:0]   heads_o,
  output logic [CW-1:0]             level_o
);
  logic [DEPTH-1:0][W-1:0] mem_q, mem_d;
  logic [CW-1:0] lvl_q, lvl_d, rem;
  logic push_ok;

  assign ready_o = (lvl_q < CW'(DEPTH));
  assign push_ok = push_i & ready_o;
  assign heads_o = mem_q;
  assign level_o = lvl_q;

  always_comb begin
    rem   = lvl_q - pop_n_i;
    mem_d = mem_q;
    // shift out popped entries
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (j == i + int'(pop_n_i)) mem_d[i] = mem_q[j];
      end
    end
    // append after the remaining entries
    for (int i = 0; i < DEPTH; i++) begin
      if (push_ok && int'(rem) == i) mem_d[i] = push_word_i;
    end
    lvl_d = rem + {{(CW-1){1'b0}}, push_ok};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      lvl_q <= '0;
    end else begin
      mem_q <= mem_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/dls_bit_timer.sv
module dls_bit_timer #(
  parameter int W  = 20,
  localparam int BW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  output logic          load_o,
  output logic          run_o,
  output logic [BW-1:0] cnt_o
);
  logic [BW-1:0] cnt_q;
  logic          run_q;

  assign load_o = sync_i | (run_q & (cnt_q == BW'(W - 1)));
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_o) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dls_lane_shifter.sv
module dls_lane_shifter #(
  parameter int W = 20,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  assign bit_o = sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= IDLE;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b1};
  end
endmodule

// File: rtl/dual_lane_serializer.sv
module dual_lane_serializer
  import dls_pkg::*;
#(
  parameter int STAGE_DEPTH = 2,
  localparam int CW = $clog2(STAGE_DEPTH + 1),
  localparam int BW = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic              two_lane_i,
  input  logic              bco_sync_i,
  output logic [LANES-1:0]  ser_o
);
  logic                          load_w, run_w;
  logic [BW-1:0]                 bit_cnt;
  logic [STAGE_DEPTH-1:0][WORD_W-1:0] heads;
  logic [CW-1:0]                 level;
  logic [CW-1:0]                 pop_n;
  logic [LANES-1:0]              lane_has;
  logic [LANES-1:0][WORD_W-1:0]  ld_word;

  dls_bit_timer #(.W(WORD_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (bco_sync_i),
    .load_o (load_w),
    .run_o  (run_w),
    .cnt_o  (bit_cnt)
  );

  dls_word_stage #(.W(WORD_W), .DEPTH(STAGE_DEPTH)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (word_valid_i),
    .push_word_i (word_i),
    .ready_o     (word_ready_o),
    .pop_n_i     (pop_n),
    .heads_o     (heads),
    .level_o     (level)
  );

  // lane l is fed when the mode allows it and enough words are staged
  always_comb begin
    pop_n = '0;
    for (int l = 0; l < LANES; l++) begin
      lane_has[l] = (level > CW'(l)) && ((l == 0) || two_lane_i);
      ld_word[l]  = lane_has[l] ? heads[l] : IDLE_WORD;
      if (load_w && lane_has[l]) pop_n = pop_n + 1'b1;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dls_lane_shifter #(.W(WORD_W), .IDLE(IDLE_WORD)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_w),
      .shift_i (run_w),
      .word_i  (ld_word[l]),
      .bit_o   (ser_o[l])
    );
  end
endmodule

// File: rtl/dls_checker.sv
module dls_checker
  import dls_pkg::*;
#(
  parameter int CW = 2,
  parameter int BW = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_w,
  input logic             run_w,
  input logic [BW-1:0]    bit_cnt,
  input logic [CW-1:0]    level,
  input logic             two_lane_i,
  input logic             bco_sync_i,
  input logic             word_ready_o,
  input logic [LANES-1:0] ser_o
);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_w && !bco_sync_i) |=> $stable(ser_o));

  assert_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && bit_cnt == BW'(WORD_W - 1)) |=> (bit_cnt == '0));

  assert_lane1_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && !two_lane_i) |=> ser_o[1] == IDLE_WORD[WORD_W-1]);

  assert_empty_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && level == '0) |=> ser_o == {LANES{IDLE_WORD[WORD_W-1]}});

  assert_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && two_lane_i && level == CW'(1)) |=> ser_o[1] == IDLE_WORD[WORD_W-1]);

  assert_full_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_ready_o && !load_w) |=> !word_ready_o);
endmodule

bind dual_lane_serializer dls_checker #(.CW(CW), .BW(BW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_w       (load_w),
  .run_w        (run_w),
  .bit_cnt      (bit_cnt),
  .level        (level),
  .two_lane_i   (two_lane_i),
  .bco_sync_i   (bco_sync_i),
  .word_ready_o (word_ready_o),
  .ser_o        (ser_o)
);

// File: tb/tb_dual_lane_serializer.sv
module tb_dual_lane_serializer;
  localparam int W = 20;
  localparam logic [W-1:0] IDLE = '1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] word_i = '0;
  logic word_valid_i = 1'b0, two_lane_i = 1'b0, bco_sync_i = 1'b0;
  logic word_ready_o;
  logic [1:0] ser_o;

  int checks = 0, errors = 0, cyc = 0;
  bit sync_on = 1'b0;
  int bco_ph = 0;

  // model state
  logic [W-1:0] q[$];
  logic [W-1:0] m_sh[2];
  string m_tag[2];
  bit m_run = 1'b0;
  int m_cnt = 0;
  bit m_last_mode = 1'b0;

  always #10 clk = ~clk;

  dual_lane_serializer dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .two_lane_i(two_lane_i), .bco_sync_i(bco_sync_i),
    .ser_o(ser_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d act=%0h exp=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] w = W'($urandom);
    if (w == IDLE) w = w ^ 20'h1;
    return w;
  endfunction

  // one clock: check current outputs, drive inputs, advance model
  task automatic step(input bit valid, input bit mode);
    bit load, acc;
    bit has[2];
    @(negedge clk);
    cyc++;
    chk(m_tag[0], 32'(ser_o[0]), 32'(m_sh[0][W-1]));
    chk(m_tag[1], 32'(ser_o[1]), 32'(m_sh[1][W-1]));
    chk("R8", 32'(word_ready_o), 32'(q.size() < 2));
    word_valid_i = valid;
    word_i       = rnd_word();
    two_lane_i   = mode;
    bco_sync_i   = sync_on && (bco_ph == 0);
    if (sync_on) bco_ph = (bco_ph + 1) % 20;
    load = bco_sync_i || (m_run && m_cnt == W - 1);
    acc  = valid && (q.size() < 2);
    if (load) begin
      has[0] = q.size() >= 1;
      has[1] = mode && q.size() >= 2;
      for (int l = 0; l < 2; l++) begin
        m_sh[l] = has[l] ? q[l] : IDLE;
        if (mode != m_last_mode) m_tag[l] = "R7";
        else if (!has[l]) m_tag[l] = (l == 1 && mode && has[0]) ? "R6" : (mode ? "R5" : (l == 1 ? "R4" : "R5"));
        else m_tag[l] = mode ? "R3" : "R2";
      end
      for (int l = 0; l < 2; l++) if (has[l]) void'(q.pop_front());
      m_last_mode = mode;
      m_cnt = 0;
      m_run = 1'b1;
    end else if (m_run) begin
      for (int l = 0; l < 2; l++) m_sh[l] = {m_sh[l][W-2:0], 1'b1};
      m_cnt++;
    end
    if (acc) q.push_back(word_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_sh[0] = IDLE; m_sh[1] = IDLE;
    m_tag[0] = "R1"; m_tag[1] = "R1";
    repeat (3) @(negedge clk);
    chk("R1", 32'(ser_o), 32'h3);
    chk("R1", 32'(word_ready_o), 32'h1);
    rst_ni = 1'b1;
    // R1: words staged before the first start pulse leave the outputs still
    repeat (6) step(1'b1, 1'b0);
    sync_on = 1'b1;
    // one-lane streaming (R2, R4)
    repeat (100) step(1'b1, 1'b0);
    // two-lane streaming (R3) with a mode change between boundaries (R7)
    repeat (7) step(1'b1, 1'b0);
    repeat (120) step(1'b1, 1'b1);
    // two-lane, one word per period (R6)
    for (int i = 0; i < 100; i++) step(i % 20 == 3, 1'b1);
    // starved lanes (R5)
    repeat (60) step(1'b0, 1'b1);
    repeat (60) step(1'b0, 1'b0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 100) < 60;
      bit m = (i / 37) % 3 != 0;
      step(v, m);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule